// File: doc/BRIEF.md
# Command Frame Decoder with Control Register Bank

This block sits behind a packet receiver that has already stripped the network headers and moved the payload into the local clock domain. It takes payload bytes one at a time, marked by a valid strobe, and keeps the most recent eight of them in a sliding window. When an end-of-frame strobe arrives, it checks the window for a fixed command layout.

A command frame opens with two marker bytes and closes with a third. Between them sit a register address and a 32-bit data word. If all three markers match, the block raises a one-cycle accept pulse and captures the address and the word. On the next cycle it writes the word into one of three configuration registers, or it fires a one-cycle restart pulse. The registers are a 2-bit channel select, a 32-bit sample count and a 32-bit rate divider. They feed the acquisition logic that follows.

Top module: `cmd_frame_decoder`

## Requirements
- R1: A command frame is eight bytes. Counting from the first byte received, byte 1 is 0x55, byte 2 is 0xA5, byte 3 is the register address, bytes 4 to 7 are the data word sent most significant byte first, and byte 8 is 0xF0.
- R2: The window is checked only in a cycle with `frame_end` high. A byte that arrives with `byte_vld` in that same cycle counts as the newest byte of the window. `cmd_accept` goes high for one cycle after the clock edge that samples `frame_end`. Bytes that arrive without `frame_end` never produce an accept.
- R3: `cmd_accept` is raised only when all three marker bytes match. A frame with any wrong marker causes no accept and no change to any output, and a correct frame sent after it is still decoded.
- R4: An accepted command with address 0 drives `restart_req` high for one cycle, starting one cycle after `cmd_accept`. `restart_req` returns low on the cycle after any edge where no command is accepted.
- R5: An accepted command with address 1 loads `chan_sel` from bits 1:0 of the data word, one cycle after `cmd_accept`.
- R6: An accepted command with address 2 loads `sample_count`, and one with address 3 loads `rate_div`, with the full 32-bit word, one cycle after `cmd_accept`.
- R7: An accepted command with any address from 4 to 255 leaves `chan_sel`, `sample_count` and `rate_div` unchanged and produces no restart pulse.
- R8: With `rst` high at a clock edge, `chan_sel`, `sample_count`, `rate_div`, `restart_req` and `cmd_accept` are zero after that edge.
- R9: The window holds the last eight bytes that had `byte_vld` high. Cycles with `byte_vld` low do not shift it, and a frame longer than eight bytes is decoded from its final eight bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Byte strobe: `byte_data` is valid this cycle |
| byte_data | input | 8 | Payload byte |
| frame_end | input | 1 | End of frame: check the window this cycle |
| cmd_accept | output | 1 | One-cycle pulse for an accepted command frame |
| restart_req | output | 1 | One-cycle restart request (address 0) |
| chan_sel | output | 2 | Channel select register (address 1) |
| sample_count | output | 32 | Sample count register (address 2) |
| rate_div | output | 32 | Rate divider register (address 3) |

## Verification
Every address from 0 to 7 is combined with several data words: all zeros, all ones, alternating bits, a word with distinct bytes, and single high bits at each end. Together these show that the four data bytes are placed in the right order, that the channel select keeps only its two low bits, and that unused addresses write nothing. Frames with exactly one bad marker, at each of the three marker positions, show that every marker is checked on its own. A good frame sent right after each bad one shows that a rejected frame leaves no trace. Long frames with leading junk bytes and idle gaps, a `frame_end` sent apart from the last byte, and eight good bytes sent with no `frame_end` at all separate the window and strobe rules from the marker check.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;

    localparam int FRAME_BYTES = 8;
    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 32;
    localparam int SEL_W       = 2;
    localparam int WORD_BYTES  = WORD_W / BYTE_W;
    localparam int ADDR_POS    = 2;
    localparam int DATA_POS    = ADDR_POS + 1;

    localparam logic [BYTE_W-1:0] MARK_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] MARK_SECOND = 8'hA5;
    localparam logic [BYTE_W-1:0] MARK_LAST   = 8'hF0;

    localparam logic [BYTE_W-1:0] ADDR_RESTART = 8'd0;
    localparam logic [BYTE_W-1:0] ADDR_CHAN    = 8'd1;
    localparam logic [BYTE_W-1:0] ADDR_COUNT   = 8'd2;
    localparam logic [BYTE_W-1:0] ADDR_RATE    = 8'd3;

    typedef logic [BYTE_W-1:0] byte_t;
    // index 0 holds the oldest byte of the window
    typedef logic [FRAME_BYTES-1:0][BYTE_W-1:0] window_t;

    typedef struct packed {
        byte_t             addr;
        logic [WORD_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic [SEL_W-1:0]  chan;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] rate;
    } cfg_t;

    function automatic logic markers_ok(input window_t w);
        return (w[0] == MARK_FIRST) && (w[1] == MARK_SECOND) &&
               (w[FRAME_BYTES-1] == MARK_LAST);
    endfunction

    function automatic cmd_t extract_cmd(input window_t w);
        cmd_t c;
        c.addr = w[ADDR_POS];
        c.data = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            c.data = {c.data[WORD_W-BYTE_W-1:0], w[DATA_POS+i]};
        end
        return c;
    endfunction

endpackage

// File: rtl/cmd_byte_window.sv
module cmd_byte_window
    import cmd_frame_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    byte_vld,
    input  byte_t   byte_data,
    output window_t win_next
);

    window_t win_q;
    window_t shifted;

    generate
        for (genvar g = 0; g < FRAME_BYTES - 1; g++) begin : g_shift
            assign shifted[g] = win_q[g+1];
        end
    endgenerate
    assign shifted[FRAME_BYTES-1] = byte_data;

    assign win_next = byte_vld ? shifted : win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_next;
        end
    end

endmodule

// File: rtl/cmd_frame_check.sv
module cmd_frame_check
    import cmd_frame_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_end,
    input  window_t win,
    output logic    cmd_vld,
    output cmd_t    cmd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_vld <= 1'b0;
            cmd     <= '0;
        end else if (frame_end && markers_ok(win)) begin
            cmd_vld <= 1'b1;
            cmd     <= extract_cmd(win);
        end else begin
            cmd_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/cmd_reg_bank.sv
module cmd_reg_bank
    import cmd_frame_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_vld,
    input  cmd_t cmd,
    output logic restart,
    output cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            restart <= 1'b0;
            cfg     <= '0;
        end else if (cmd_vld) begin
            unique case (cmd.addr)
                ADDR_RESTART: restart   <= 1'b1;
                ADDR_CHAN:    cfg.chan  <= cmd.data[SEL_W-1:0];
                ADDR_COUNT:   cfg.count <= cmd.data;
                ADDR_RATE:    cfg.rate  <= cmd.data;
                default:      ;
            endcase
        end else begin
            restart <= 1'b0;
        end
    end

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
    import cmd_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    input  logic        frame_end,
    output logic        cmd_accept,
    output logic        restart_req,
    output logic [1:0]  chan_sel,
    output logic [31:0] sample_count,
    output logic [31:0] rate_div
);

    window_t win_next;
    cmd_t    cmd;
    cfg_t    cfg;

    cmd_byte_window u_window (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .win_next  (win_next)
    );

    cmd_frame_check u_check (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .win       (win_next),
        .cmd_vld   (cmd_accept),
        .cmd       (cmd)
    );

    cmd_reg_bank u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd_vld (cmd_accept),
        .cmd     (cmd),
        .restart (restart_req),
        .cfg     (cfg)
    );

    assign chan_sel     = cfg.chan;
    assign sample_count = cfg.count;
    assign rate_div     = cfg.rate;

endmodule

// File: rtl/cmd_frame_decoder_chk.sv
module cmd_frame_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_end,
    input logic        cmd_accept,
    input logic        restart_req,
    input logic [1:0]  chan_sel,
    input logic [31:0] sample_count,
    input logic [31:0] rate_div
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R8: one edge with reset high leaves every output at zero
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            p_reset_zero_r8: assert (!cmd_accept && !restart_req && chan_sel == '0 &&
                                     sample_count == '0 && rate_div == '0)
                else $error("reset values wrong");
        end
    end

    p_accept_needs_end_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> $past(frame_end))
        else $error("accept without end-of-frame");

    p_restart_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(restart_req) |-> $past(cmd_accept))
        else $error("restart without accepted command");

    p_restart_clears_r4: assert property (@(posedge clk) disable iff (rst)
        !cmd_accept |=> !restart_req)
        else $error("restart held without command");

    p_regs_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_accept |=> ($stable(chan_sel) && $stable(sample_count) && $stable(rate_div)))
        else $error("register changed without command");

endmodule

bind cmd_frame_decoder cmd_frame_decoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_end    (frame_end),
    .cmd_accept   (cmd_accept),
    .restart_req  (restart_req),
    .chan_sel     (chan_sel),
    .sample_count (sample_count),
    .rate_div     (rate_div)
);

// File: tb/cmd_frame_decoder_tb.sv
module cmd_frame_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        frame_end = 1'b0;
    logic        cmd_accept, restart_req;
    logic [1:0]  chan_sel;
    logic [31:0] sample_count, rate_div;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [1:0]  e_chan  = '0;
    logic [31:0] e_count = '0;
    logic [31:0] e_rate  = '0;

    always #10 clk = ~clk;

    cmd_frame_decoder u_dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_end(frame_end), .cmd_accept(cmd_accept), .restart_req(restart_req),
        .chan_sel(chan_sel), .sample_count(sample_count), .rate_div(rate_div)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic eop);
        byte_vld  = 1'b1;
        byte_data = b;
        frame_end = eop;
        @(negedge clk);
        byte_vld  = 1'b0;
        frame_end = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_frame(input logic [7:0] m0, input logic [7:0] m1,
                              input logic [7:0] a, input logic [31:0] d,
                              input logic [7:0] m2, input logic eop);
        push(m0, 1'b0);
        push(m1, 1'b0);
        push(a, 1'b0);
        for (int i = 3; i >= 0; i--) push(d[i*8 +: 8], 1'b0);
        push(m2, eop);
    endtask

    task automatic check_regs(input string tag);
        chk({30'd0, chan_sel}, {30'd0, e_chan}, {tag, " chan_sel"});
        chk(sample_count, e_count, {tag, " sample_count"});
        chk(rate_div, e_rate, {tag, " rate_div"});
    endtask

    // called at the negedge right after the edge that sampled frame_end
    task automatic expect_cmd(input logic [7:0] a, input logic [31:0] d, input logic good,
                              input string tag);
        chk({31'd0, cmd_accept}, {31'd0, good}, {tag, " R2/R3 accept"});
        if (good) begin
            case (a)
                8'd1: e_chan  = d[1:0];
                8'd2: e_count = d;
                8'd3: e_rate  = d;
                default: ;
            endcase
        end
        @(negedge clk);
        chk({31'd0, cmd_accept}, 32'd0, {tag, " R2 accept one cycle"});
        chk({31'd0, restart_req}, {31'd0, good && a == 8'd0}, {tag, " R4 restart"});
        check_regs({tag, " R5/R6/R7"});
        @(negedge clk);
        chk({31'd0, restart_req}, 32'd0, {tag, " R4 restart clears"});
    endtask

    initial begin : main
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hAAAA_5555;
        pats[3] = 32'h1234_5678; pats[4] = 32'h8000_0001; pats[5] = 32'h0000_0002;

        idle(3);
        rst = 1'b0;
        chk({31'd0, cmd_accept}, 32'd0, "R8 reset accept");
        chk({31'd0, restart_req}, 32'd0, "R8 reset restart");
        check_regs("R8 reset");

        // R1 R4 R5 R6 R7: address and data sweep
        for (int a = 0; a < 8; a++) begin
            for (int p = 0; p < 6; p++) begin
                push_frame(8'h55, 8'hA5, 8'(a), pats[p] ^ 32'(a), 8'hF0, 1'b1);
                expect_cmd(8'(a), pats[p] ^ 32'(a), 1'b1, $sformatf("R1 sweep a=%0d", a));
            end
        end
        // R7: a high address
        push_frame(8'h55, 8'hA5, 8'hFF, 32'h0BAD_0BAD, 8'hF0, 1'b1);
        expect_cmd(8'hFF, 32'h0BAD_0BAD, 1'b1, "R7 addr 255");

        // R3: one wrong marker at a time, each followed by a good frame
        for (int m = 0; m < 3; m++) begin
            push_frame(m == 0 ? 8'h54 : 8'h55, m == 1 ? 8'hA4 : 8'hA5, 8'd2,
                       32'hDEAD_0000 + 32'(m), m == 2 ? 8'hF1 : 8'hF0, 1'b1);
            expect_cmd(8'd2, 32'hDEAD_0000, 1'b0, $sformatf("R3 bad marker %0d", m));
            push_frame(8'h55, 8'hA5, 8'd3, 32'h0000_1000 + 32'(m), 8'hF0, 1'b1);
            expect_cmd(8'd3, 32'h0000_1000 + 32'(m), 1'b1, "R3 recover");
        end

        // R2: good bytes with no end strobe produce nothing
        push_frame(8'h55, 8'hA5, 8'd2, 32'h7777_7777, 8'hF0, 1'b0);
        expect_cmd(8'd2, 32'h7777_7777, 1'b0, "R2 no end strobe");
        // R2: end strobe alone, after the bytes, judges the held window
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        expect_cmd(8'd2, 32'h7777_7777, 1'b1, "R2 separate end strobe");

        // R9: leading junk bytes and idle gaps, decoded from the last eight
        push(8'h55, 1'b0); push(8'hA5, 1'b0); push(8'h01, 1'b0);
        push(8'h55, 1'b0); idle(2); push(8'hA5, 1'b0); idle(1);
        push(8'd1, 1'b0); push(8'h00, 1'b0); idle(3); push(8'h00, 1'b0);
        push(8'h00, 1'b0); push(8'h03, 1'b0); idle(1); push(8'hF0, 1'b1);
        expect_cmd(8'd1, 32'h0000_0003, 1'b1, "R9 long frame");
        // R9: trailing extra byte shifts the frame out of place
        push_frame(8'h55, 8'hA5, 8'd2, 32'h5555_0000, 8'hF0, 1'b0);
        push(8'hF0, 1'b1);
        expect_cmd(8'd2, 32'h5555_0000, 1'b0, "R9 misaligned");

        // R8: reset after configuration
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        e_chan = '0; e_count = '0; e_rate = '0;
        chk({31'd0, restart_req}, 32'd0, "R8 mid reset restart");
        check_regs("R8 mid reset");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : watchdog
        #(20 * 100000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule